// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a load-multiple or store-multiple instruction. When `start_i` is pulsed it captures a register list, a base address and the mode bits (pre-index, up, writeback, load, S). It then runs one word access per selected register over a request/acknowledge bus, from the lowest register index to the highest. Each access carries a sequential/non-sequential attribute, the register index, and a read or write strobe for the register file, which sits outside this block.

The sequencer computes the first address for all four addressing modes, so the bus always walks upward in steps of four bytes. It also produces the written-back base value and orders its write strobe against the transfers: before them for loads, so that a base register in the list keeps its loaded value, and after them for stores. It reports when the user register bank is to be used, requests a copy of the saved status into the current status, and marks the end of the instruction with an idle cycle for loads or a non-sequential fetch hint for stores.

Top module: `block_xfer_seq`

## Requirements
- R1: The first access address is base when pre=0,up=1; base+4 when pre=1,up=1; base-4*N when pre=1,up=0; and base-4*N+4 when pre=0,up=0, where N is the number of set bits in the list.
- R2: Accesses go to the set list bits in ascending index order (`reg_idx_o`), and each address is 4 more than the one before.
- R3: `seq_o` is 0 on the first access of an instruction and 1 on every later access.
- R4: `base_val_o` is base+4*N when up=1 and base-4*N when up=0, and `base_wr_o` is never asserted when wb=0.
- R5: For a load with wb=1, `base_wr_o` is high for one cycle immediately before the first access. For a store with wb=1, it is high in the cycle right after the last acknowledged access.
- R6: During the accesses, `user_bank_o` is 1 exactly when S=1 and either the operation is a store or list bit NREG-1 is clear.
- R7: `psr_restore_o` pulses in the closing cycle only for a load with S=1, list bit NREG-1 set, and `exc_mode_i`=1 at start.
- R8: The cycle after the last access is a closing cycle. In it, `idle_o`=1 for a load, or `fetch_nseq_o`=1 for a store, never both.
- R9: An empty list makes no request, and `done_o` is 1 in the cycle after start.
- R10: While `ack_i` is low, `req_o` stays high and `addr_o` and `reg_idx_o` hold their values.
- R11: `we_o` is 1 on store accesses only. `reg_wr_o` is 1 only in a cycle where a load access is acknowledged.
- R12: `done_o` is a one-cycle pulse one cycle after the closing cycle, and `busy_o` is 0 in the cycle that follows it. List and base inputs changed after start have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (accepted when idle) |
| list_i | input | NREG | Register selection list |
| base_i | input | AW | Base register value |
| pre_i | input | 1 | 1 = pre-index, 0 = post-index |
| up_i | input | 1 | 1 = ascending, 0 = descending |
| wb_i | input | 1 | Write the updated base back |
| load_i | input | 1 | 1 = load, 0 = store |
| sbit_i | input | 1 | User-bank / status-restore bit |
| exc_mode_i | input | 1 | Current mode has a saved status |
| req_o | output | 1 | Bus request |
| we_o | output | 1 | Bus write |
| seq_o | output | 1 | Sequential attribute of this access |
| addr_o | output | AW | Word address of the access |
| ack_i | input | 1 | Bus acknowledge |
| reg_idx_o | output | IW | Register index of the current access |
| reg_wr_o | output | 1 | Register file write strobe (load data) |
| reg_rd_o | output | 1 | Register file read strobe (store data) |
| base_wr_o | output | 1 | Base register write strobe |
| base_val_o | output | AW | Base writeback value |
| user_bank_o | output | 1 | Access the user register bank |
| psr_restore_o | output | 1 | Copy saved status to current status |
| idle_o | output | 1 | Internal idle cycle closing a load |
| fetch_nseq_o | output | 1 | Next fetch is non-sequential (store close) |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Instruction complete pulse |

## Verification
The assertions check, on every cycle, that a stalled request holds its address and index, that the index and address only move upward after an acknowledge, that the first access is non-sequential and later ones sequential, that a base write never meets a load write, and that the closing cycle never raises both the idle and fetch hints. The correct start address for each addressing mode, the writeback value, the exact base-write placement relative to the transfers, the user-bank and status-restore decisions, and the empty-list timing can only be shown by the bench's scenarios. Those scenarios compare against values computed from the list, base and mode bits, with random acknowledge delays.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBPRE,
    ST_XFER,
    ST_TAIL,
    ST_DONE
  } bts_state_e;
endpackage

// File: rtl/bts_addr_calc.sv
module bts_addr_calc #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  localparam int unsigned CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] list_i,
  input  logic [AW-1:0]   base_i,
  input  logic            pre_i,
  input  logic            up_i,
  output logic [CW-1:0]   count_o,
  output logic [AW-1:0]   start_o,
  output logic [AW-1:0]   wb_val_o
);
  import bts_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] span;

  always_comb begin
    count_o = '0;
    for (int i = 0; i < NREG; i++) count_o = count_o + CW'(list_i[i]);
  end

  assign span = AW'(count_o) * STEP;

  // every mode is turned into an ascending walk from its lowest address
  always_comb begin
    unique case ({pre_i, up_i})
      2'b01:   start_o = base_i;
      2'b11:   start_o = base_i + STEP;
      2'b10:   start_o = base_i - span;
      default: start_o = base_i - span + STEP;
    endcase
  end

  assign wb_val_o = up_i ? base_i + span : base_i - span;
endmodule

// File: rtl/bts_lowest_set.sv
module bts_lowest_set #(
  parameter int unsigned N   = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/block_xfer_seq.sv
module block_xfer_seq #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned CW  = $clog2(NREG + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NREG-1:0] list_i,
  input  logic [AW-1:0]   base_i,
  input  logic            pre_i,
  input  logic            up_i,
  input  logic            wb_i,
  input  logic            load_i,
  input  logic            sbit_i,
  input  logic            exc_mode_i,
  output logic            req_o,
  output logic            we_o,
  output logic            seq_o,
  output logic [AW-1:0]   addr_o,
  input  logic            ack_i,
  output logic [IW-1:0]   reg_idx_o,
  output logic            reg_wr_o,
  output logic            reg_rd_o,
  output logic            base_wr_o,
  output logic [AW-1:0]   base_val_o,
  output logic            user_bank_o,
  output logic            psr_restore_o,
  output logic            idle_o,
  output logic            fetch_nseq_o,
  output logic            busy_o,
  output logic            done_o
);
  import bts_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  localparam int unsigned   PC_IDX = NREG - 1;

  bts_state_e      state_q, state_d;
  logic [NREG-1:0] pend_q, pend_nxt;
  logic [AW-1:0]   addr_q, wbv_q;
  logic            first_q, load_q, wb_q, ubank_q, restore_q;

  logic [CW-1:0]   count;
  logic [AW-1:0]   start_addr, wb_val;
  logic [IW-1:0]   cur_idx;
  logic            cur_any, remain;

  bts_addr_calc #(.NREG(NREG), .AW(AW)) u_addr (
    .list_i  (list_i),
    .base_i  (base_i),
    .pre_i   (pre_i),
    .up_i    (up_i),
    .count_o (count),
    .start_o (start_addr),
    .wb_val_o(wb_val)
  );

  bts_lowest_set #(.N(NREG)) u_pick (
    .vec_i(pend_q),
    .idx_o(cur_idx),
    .any_o(cur_any)
  );

  // clearing the lowest set bit retires the current register
  assign pend_nxt = pend_q & (pend_q - NREG'(1));
  assign remain   = |pend_nxt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin
                  if (count == '0)        state_d = ST_DONE;
                  else if (load_i && wb_i) state_d = ST_WBPRE;
                  else                    state_d = ST_XFER;
                end
      ST_WBPRE: state_d = ST_XFER;
      ST_XFER:  if (ack_i && !remain) state_d = ST_TAIL;
      ST_TAIL:  state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      addr_q    <= '0;
      wbv_q     <= '0;
      first_q   <= 1'b0;
      load_q    <= 1'b0;
      wb_q      <= 1'b0;
      ubank_q   <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        pend_q    <= list_i;
        addr_q    <= start_addr;
        wbv_q     <= wb_val;
        first_q   <= 1'b1;
        load_q    <= load_i;
        wb_q      <= wb_i;
        ubank_q   <= sbit_i && (!load_i || !list_i[PC_IDX]);
        restore_q <= load_i && sbit_i && list_i[PC_IDX] && exc_mode_i;
      end else if (state_q == ST_XFER && ack_i) begin
        pend_q  <= pend_nxt;
        addr_q  <= addr_q + STEP;
        first_q <= 1'b0;
      end
    end
  end

  assign req_o         = (state_q == ST_XFER);
  assign we_o          = req_o && !load_q;
  assign seq_o         = req_o && !first_q;
  assign addr_o        = addr_q;
  assign reg_idx_o     = cur_idx;
  assign reg_wr_o      = req_o && ack_i && load_q;
  assign reg_rd_o      = req_o && !load_q;
  assign base_wr_o     = (state_q == ST_WBPRE) || (state_q == ST_TAIL && wb_q && !load_q);
  assign base_val_o    = wbv_q;
  assign user_bank_o   = req_o && ubank_q;
  assign psr_restore_o = (state_q == ST_TAIL) && restore_q;
  assign idle_o        = (state_q == ST_TAIL) && load_q;
  assign fetch_nseq_o  = (state_q == ST_TAIL) && !load_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);

  assert_req_has_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cur_any);

  assert_idx_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> (!req_o || (reg_idx_o > $past(reg_idx_o))));

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> (!req_o || (addr_o == $past(addr_o) + STEP)));

  assert_first_nseq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !seq_o);

  assert_later_seq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> (!req_o || seq_o));

  assert_store_wb_after_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr_o && !load_q) |-> $past(req_o && ack_i));

  assert_load_wb_before_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr_o && load_q) |=> (req_o && !seq_o));

  assert_close_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idle_o && fetch_nseq_o));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(reg_idx_o)));

  assert_no_wr_clash_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(base_wr_o && reg_wr_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/block_xfer_seq_test.sv
`timescale 1ns/1ps
module block_xfer_seq_test;
  localparam int NREG = 16;
  localparam int AW   = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [NREG-1:0] list_i = '0;
  logic [AW-1:0]   base_i = '0;
  logic            pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
  logic            sbit_i = 1'b0, exc_mode_i = 1'b0, ack_i = 1'b0;
  logic            req_o, we_o, seq_o, reg_wr_o, reg_rd_o, base_wr_o;
  logic [AW-1:0]   addr_o, base_val_o;
  logic [3:0]      reg_idx_o;
  logic            user_bank_o, psr_restore_o, idle_o, fetch_nseq_o, busy_o, done_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  block_xfer_seq uut (
    .clk_i, .rst_ni, .start_i, .list_i, .base_i, .pre_i, .up_i, .wb_i, .load_i,
    .sbit_i, .exc_mode_i, .req_o, .we_o, .seq_o, .addr_o, .ack_i, .reg_idx_o,
    .reg_wr_o, .reg_rd_o, .base_wr_o, .base_val_o, .user_bank_o, .psr_restore_o,
    .idle_o, .fetch_nseq_o, .busy_o, .done_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int popc(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(l[i]);
    return c;
  endfunction

  function automatic logic [31:0] first_addr(input logic [31:0] b, input logic [15:0] l,
                                             input logic p, input logic u);
    logic [31:0] n4 = 32'(popc(l)) * 32'd4;
    if (!p && u) return b;
    if (p && u) return b + 32'd4;
    if (p && !u) return b - n4;
    return b - n4 + 32'd4;
  endfunction

  function automatic logic [31:0] new_base(input logic [31:0] b, input logic [15:0] l, input logic u);
    logic [31:0] n4 = 32'(popc(l)) * 32'd4;
    return u ? b + n4 : b - n4;
  endfunction

  task automatic run_op(input logic [15:0] l, input logic [31:0] b, input logic p, input logic u,
                        input logic w, input logic ld, input logic s, input logic x);
    logic [31:0] a  = first_addr(b, l, p, u);
    logic [31:0] nb = new_base(b, l, u);
    bit          first = 1'b1;
    @(negedge clk_i);
    list_i = l; base_i = b; pre_i = p; up_i = u; wb_i = w; load_i = ld;
    sbit_i = s; exc_mode_i = x; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // scramble captured inputs: must not matter (R12)
    list_i = 16'($urandom); base_i = $urandom; pre_i = ~p; up_i = ~u; load_i = ~ld;
    if (l == '0) begin
      chk("R9 done after start", 32'(done_o), 32'd1);
      chk("R9 no request", 32'(req_o), 32'd0);
      @(negedge clk_i);
      chk("R9 back to idle", 32'(busy_o), 32'd0);
      return;
    end
    if (ld && w) begin
      chk("R5 load base write before access", 32'(base_wr_o), 32'd1);
      chk("R5 no request during base write", 32'(req_o), 32'd0);
      chk("R4 load writeback value", base_val_o, nb);
      @(negedge clk_i);
    end else begin
      chk("R4 R5 no early base write", 32'(base_wr_o), 32'd0);
    end
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin
        int dly = $urandom_range(0, 2);
        for (int k = 0; k <= dly; k++) begin
          chk("R10 request held", 32'(req_o), 32'd1);
          chk(first ? "R1 start address" : "R2 address step", addr_o, a);
          chk("R2 register order", 32'(reg_idx_o), 32'(i));
          chk("R3 sequential attribute", 32'(seq_o), 32'(!first));
          chk("R11 write enable", 32'(we_o), 32'(!ld));
          chk("R6 user bank", 32'(user_bank_o), 32'(s && (!ld || !l[15])));
          chk("R4 R5 no base write mid-transfer", 32'(base_wr_o), 32'd0);
          ack_i = (k == dly);
          #1;
          chk("R11 load write strobe", 32'(reg_wr_o), 32'(ack_i && ld));
          @(negedge clk_i);
          ack_i = 1'b0;
        end
        a = a + 32'd4;
        first = 1'b0;
      end
    end
    chk("R8 request dropped", 32'(req_o), 32'd0);
    chk("R8 load idle cycle", 32'(idle_o), 32'(ld));
    chk("R8 store fetch hint", 32'(fetch_nseq_o), 32'(!ld));
    chk("R5 store base write after access", 32'(base_wr_o), 32'(!ld && w));
    if (!ld && w) chk("R4 store writeback value", base_val_o, nb);
    chk("R7 status restore", 32'(psr_restore_o), 32'(ld && s && l[15] && x));
    @(negedge clk_i);
    chk("R12 done pulse", 32'(done_o), 32'd1);
    chk("R8 close cycle over", 32'(idle_o | fetch_nseq_o), 32'd0);
    @(negedge clk_i);
    chk("R12 done cleared", 32'(done_o), 32'd0);
    chk("R12 idle again", 32'(busy_o), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk("R12 reset busy", 32'(busy_o), 32'd0);
    chk("R12 reset done", 32'(done_o), 32'd0);
    chk("R10 reset request", 32'(req_o), 32'd0);
    rst_ni = 1'b1;
    // four addressing modes, loads and stores
    run_op(16'h00F1, 32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(16'h00F1, 32'h0000_1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op(16'h8421, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(16'h8421, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // empty list
    run_op(16'h0000, 32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    // single register, full list, base wraparound
    run_op(16'h0001, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op(16'hFFFF, 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // S bit variants
    run_op(16'h8003, 32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_op(16'h8003, 32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(16'h0003, 32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_op(16'h8003, 32'h0000_4000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [31:0] r = $urandom;
      logic [15:0] l = 16'($urandom);
      if (r[9:8] == 2'b00) l = l & 16'($urandom);
      run_op(l, {$urandom} & 32'hFFFF_FFFC, r[0], r[1], r[2], r[3], r[4], r[5]);
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule